// File: doc/BRIEF.md
# Reconfigurable Multi-Port Memory Emulator

This block gives several function units parallel access to one shared store without true multi-ported cells. Every read port owns a private column bank that has a single read side. A word written through any write port is copied into every column bank of that port's partition, so each read port can fetch any address on its own.

A mode register sets how the columns are grouped. In unified mode all sixteen read ports and all four write ports form one memory. In halves mode they form two independent memories, each with eight read ports and two write ports. In quarters mode they form four independent memories, each with four read ports and one write port. Every partition holds the full word depth in every mode. A mode change affects only where later writes are copied. Stored data stays in place.

Top module: `mpm_multiport`

## Requirements
- R1: After reset, every read data output is zero and every stored word is zero. The mode is unified (code 0).
- R2: In unified mode (cfg code 0), a valid write from any write port updates the addressed word in all sixteen read columns.
- R3: In halves mode (cfg code 1), write ports 0–1 update only read columns 0–7, and write ports 2–3 update only read columns 8–15.
- R4: In quarters mode (cfg code 2), write port w updates only read columns 4w to 4w+3.
- R5: When two or more valid write ports of the same partition target the same address in one cycle, the lowest-numbered port's data is stored.
- R6: A read returns data on the clock edge after the edge that samples the read enable and address. While the enable is low, the read data output holds its last value.
- R7: A read of an address that is being written in the same cycle returns the value stored before that write.
- R8: A cfg code is sampled at a clock edge and governs writes from the next edge onward. A write sampled at the same edge as the new code still uses the previous mode.
- R9: Changing the mode does not alter any stored word.
- R10: Cfg code 3 is ignored, and the previous mode stays in force.
- R11: A write port whose valid bit is low changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_mode_i | input | 2 | Partition mode request: 0 unified, 1 halves, 2 quarters, 3 ignored |
| wr_valid_i | input | NUM_WR | Write valid, one bit per write port |
| wr_addr_i | input | NUM_WR*ADDR_W | Write addresses; port w uses bits [w*ADDR_W +: ADDR_W] |
| wr_data_i | input | NUM_WR*DATA_W | Write data; port w uses bits [w*DATA_W +: DATA_W] |
| rd_en_i | input | NUM_RD | Read enable, one bit per read port |
| rd_addr_i | input | NUM_RD*ADDR_W | Read addresses; port r uses bits [r*ADDR_W +: ADDR_W] |
| rd_data_o | output | NUM_RD*DATA_W | Registered read data; port r on bits [r*DATA_W +: DATA_W] |

## Verification
A column bank with a wrong word shows up only on the one read port that owns it. The bench therefore reads every address on every port after each write pattern, and a missed or leaked broadcast appears one cycle after the read is issued. A mode register that loads the wrong value misroutes the very next write, so the bench reads back right after each mode switch and right after each ignored code. Write-priority and read-before-write faults are exposed by single-cycle collisions that are checked on the following cycle.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
  typedef enum logic [1:0] {
    MODE_UNIFIED  = 2'd0,
    MODE_HALVES   = 2'd1,
    MODE_QUARTERS = 2'd2
  } mode_e;

  localparam logic [1:0] MODE_RSVD = 2'd3;

  // partition index of a column or write port; lvl = log2(partition count)
  function automatic int group_of(int idx, int idx_lg, int lvl);
    return idx >> (idx_lg - lvl);
  endfunction
endpackage

// File: rtl/mpm_cfg_reg.sv
module mpm_cfg_reg
  import mpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cfg_mode_i,
  output mode_e      mode_o
);
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_UNIFIED;
    else if (cfg_mode_i != MODE_RSVD) mode_q <= mode_e'(cfg_mode_i);
  end

  assign mode_o = mode_q;

  p_mode_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i != MODE_RSVD) |=> (mode_q == mode_e'($past(cfg_mode_i))));

  p_mode_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == MODE_RSVD) |=> $stable(mode_q));
endmodule

// File: rtl/mpm_wr_router.sv
module mpm_wr_router
  import mpm_pkg::*;
#(
  parameter int NUM_RD = 16,
  parameter int NUM_WR = 4
) (
  input  mode_e                          mode_i,
  input  logic [NUM_WR-1:0]              wr_valid_i,
  output logic [NUM_RD-1:0][NUM_WR-1:0]  col_gnt_o
);
  localparam int RD_LG = $clog2(NUM_RD);
  localparam int WR_LG = $clog2(NUM_WR);

  // closed bus switches: a port reaches a column when both sit in one group
  always_comb begin
    for (int c = 0; c < NUM_RD; c++) begin
      for (int w = 0; w < NUM_WR; w++) begin
        col_gnt_o[c][w] = wr_valid_i[w] &&
          (group_of(c, RD_LG, int'(mode_i)) == group_of(w, WR_LG, int'(mode_i)));
      end
    end
  end
endmodule

// File: rtl/mpm_col_bank.sv
module mpm_col_bank #(
  parameter int NUM_WR = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_WR-1:0]        wr_gnt_i,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr_i,
  input  logic [NUM_WR*DATA_W-1:0] wr_data_i,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0]             mem_q [DEPTH];
  logic [DATA_W-1:0]             rd_q;
  logic [DEPTH-1:0]              wen;
  logic [DEPTH-1:0][DATA_W-1:0]  wval;

  // descending scan: lowest-numbered port is applied last and wins
  always_comb begin
    for (int a = 0; a < DEPTH; a++) begin
      wen[a]  = 1'b0;
      wval[a] = '0;
      for (int w = NUM_WR - 1; w >= 0; w--) begin
        if (wr_gnt_i[w] && (wr_addr_i[w*ADDR_W +: ADDR_W] == ADDR_W'(a))) begin
          wen[a]  = 1'b1;
          wval[a] = wr_data_i[w*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
      rd_q <= '0;
    end else begin
      for (int a = 0; a < DEPTH; a++) begin
        if (wen[a]) mem_q[a] <= wval[a];
      end
      if (rd_en_i) rd_q <= mem_q[rd_addr_i];
    end
  end

  assign rd_data_o = rd_q;

  p_port0_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_gnt_i[0] |=> (mem_q[$past(wr_addr_i[ADDR_W-1:0])] == $past(wr_data_i[DATA_W-1:0])));

  p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  p_rd_old_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_data_o == $past(mem_q[rd_addr_i])));
endmodule

// File: rtl/mpm_multiport.sv
module mpm_multiport
  import mpm_pkg::*;
#(
  parameter int NUM_RD = 16,
  parameter int NUM_WR = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               cfg_mode_i,
  input  logic [NUM_WR-1:0]        wr_valid_i,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr_i,
  input  logic [NUM_WR*DATA_W-1:0] wr_data_i,
  input  logic [NUM_RD-1:0]        rd_en_i,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr_i,
  output logic [NUM_RD*DATA_W-1:0] rd_data_o
);
  mode_e                         mode;
  logic [NUM_RD-1:0][NUM_WR-1:0] col_gnt;

  mpm_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_mode_i (cfg_mode_i),
    .mode_o     (mode)
  );

  mpm_wr_router #(.NUM_RD(NUM_RD), .NUM_WR(NUM_WR)) u_router (
    .mode_i     (mode),
    .wr_valid_i (wr_valid_i),
    .col_gnt_o  (col_gnt)
  );

  for (genvar c = 0; c < NUM_RD; c++) begin : g_col
    mpm_col_bank #(.NUM_WR(NUM_WR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_gnt_i  (col_gnt[c]),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_en_i   (rd_en_i[c]),
      .rd_addr_i (rd_addr_i[c*ADDR_W +: ADDR_W]),
      .rd_data_o (rd_data_o[c*DATA_W +: DATA_W])
    );
  end

  p_unified_bcast_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_UNIFIED) |-> ((col_gnt[0] == wr_valid_i) && (col_gnt[NUM_RD-1] == wr_valid_i)));

  p_halves_split_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_HALVES) |-> (!col_gnt[0][NUM_WR-1] && !col_gnt[NUM_RD-1][0]));

  p_quarters_split_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_QUARTERS) |-> ($countones(col_gnt[0]) <= 1 && !col_gnt[0][1]));
endmodule

// File: tb/mpm_multiport_tb_top.sv
module mpm_multiport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NRD = 16;
  localparam int NWR = 4;
  localparam int AW  = 4;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg = 2'd0;
  logic [NWR-1:0] wv = '0;
  logic [AW-1:0] wa [NWR];
  logic [DW-1:0] wd [NWR];
  logic [NRD-1:0] re = '0;
  logic [AW-1:0] ra [NRD];
  logic [NWR*AW-1:0] wa_flat;
  logic [NWR*DW-1:0] wd_flat;
  logic [NRD*AW-1:0] ra_flat;
  logic [NRD*DW-1:0] rd_flat;

  logic [DW-1:0] model [NRD][1<<AW];
  logic [DW-1:0] exp_rd [NRD];
  int mode_m = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int w = 0; w < NWR; w++) begin
      wa_flat[w*AW +: AW] = wa[w];
      wd_flat[w*DW +: DW] = wd[w];
    end
    for (int p = 0; p < NRD; p++) ra_flat[p*AW +: AW] = ra[p];
  end

  mpm_multiport dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_mode_i (cfg),
    .wr_valid_i (wv),
    .wr_addr_i  (wa_flat),
    .wr_data_i  (wd_flat),
    .rd_en_i    (re),
    .rd_addr_i  (ra_flat),
    .rd_data_o  (rd_flat)
  );

  // one clock: update the requirement model at the edge, return at negedge
  task automatic tick();
    @(posedge clk);
    for (int p = 0; p < NRD; p++) if (re[p]) exp_rd[p] = model[p][ra[p]];
    for (int c = 0; c < NRD; c++)
      for (int w = NWR - 1; w >= 0; w--)
        if (wv[w] && ((c >> (4 - mode_m)) == (w >> (2 - mode_m)))) model[c][wa[w]] = wd[w];
    if (cfg != 2'd3) mode_m = int'(cfg);
    @(negedge clk);
  endtask

  task automatic check_rd(string tag);
    for (int p = 0; p < NRD; p++) begin
      checks++;
      if (rd_flat[p*DW +: DW] !== exp_rd[p]) begin
        failures++;
        $display("FAIL %s port %0d actual=%02h expected=%02h", tag, p, rd_flat[p*DW +: DW], exp_rd[p]);
      end
    end
  endtask

  task automatic idle();
    wv = '0;
    re = '0;
  endtask

  task automatic read_addr(int a, string tag);
    re = '1;
    for (int p = 0; p < NRD; p++) ra[p] = AW'(a);
    tick();
    re = '0;
    check_rd(tag);
  endtask

  task automatic read_sweep(string tag);
    for (int a = 0; a < (1 << AW); a++) read_addr(a, tag);
  endtask

  task automatic set_mode(int m);
    cfg = 2'(m);
    tick();
  endtask

  task automatic write1(int w, int a, int d);
    wv = '0;
    wv[w] = 1'b1;
    wa[w] = AW'(a);
    wd[w] = DW'(d);
  endtask

  initial begin
    for (int c = 0; c < NRD; c++) begin
      exp_rd[c] = '0;
      ra[c] = '0;
      for (int a = 0; a < (1 << AW); a++) model[c][a] = '0;
    end
    for (int w = 0; w < NWR; w++) begin
      wa[w] = '0;
      wd[w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: outputs and storage cleared by reset
    check_rd("R1");
    read_sweep("R1");

    // R2/R3/R4: full write sweep per mode, distinct addresses per port
    for (int m = 0; m < 3; m++) begin
      set_mode(m);
      for (int a = 0; a < (1 << AW); a++) begin
        wv = '1;
        for (int w = 0; w < NWR; w++) begin
          wa[w] = AW'((a + 4 * w) % 16);
          wd[w] = DW'(m * 64 + w * 16 + a * 7 + 1);
        end
        tick();
      end
      idle();
      read_sweep(m == 0 ? "R2" : (m == 1 ? "R3" : "R4"));
    end

    // R5: same-address collisions
    set_mode(0);
    wv = '1;
    for (int w = 0; w < NWR; w++) begin
      wa[w] = AW'(5);
      wd[w] = DW'(8'h90 + w);
    end
    tick();
    idle();
    read_addr(5, "R5");
    set_mode(1);
    wv = '1;
    for (int w = 0; w < NWR; w++) begin
      wa[w] = AW'(6);
      wd[w] = DW'(8'hB0 + w);
    end
    tick();
    idle();
    read_addr(6, "R5");

    // R6: enable low holds the output while storage changes
    write1(0, 6, 8'h11);
    tick();
    idle();
    tick();
    check_rd("R6");

    // R7: read-during-write returns the old word
    write1(0, 7, 8'h22);
    re = '1;
    for (int p = 0; p < NRD; p++) ra[p] = AW'(7);
    tick();
    idle();
    check_rd("R7");
    read_addr(7, "R7");

    // R8: write sampled with the new code uses the previous mode
    cfg = 2'd2;
    write1(1, 9, 8'hA5);
    tick();
    idle();
    read_addr(9, "R8");
    write1(1, 10, 8'h5A);
    tick();
    idle();
    read_addr(10, "R8");

    // R9: mode changes keep contents
    set_mode(1);
    set_mode(0);
    read_sweep("R9");

    // R10: code 3 leaves quarters mode in force
    set_mode(2);
    cfg = 2'd3;
    tick();
    write1(0, 11, 8'h3C);
    tick();
    idle();
    read_addr(11, "R10");
    write1(3, 12, 8'h4D);
    tick();
    idle();
    read_addr(12, "R10");

    // R11: invalid write ports leave storage untouched
    cfg = 2'd0;
    tick();
    wv = '0;
    for (int w = 0; w < NWR; w++) begin
      wa[w] = AW'(13);
      wd[w] = DW'(8'hEE);
    end
    tick();
    read_addr(13, "R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule